// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Output

This block is a small counter/timer with one compare register and one waveform output. A count-enable tick moves the counter forward. The counter either runs freely and wraps at its all-ones value, or returns to zero after it matches the compare register, so the compare value sets the period. A match can toggle, clear or set the waveform output, or leave it alone. The choice comes from a 2-bit action field.

Software reaches the counter, the compare value, a 3-bit mode field and the action field through separate write strobes. A force strobe applies the selected action to the output at once, without a real match. Two sticky flags report events: one for counter wrap and one for compare match. Each flag is cleared by a write-one-to-clear input.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, compare value, mode, action, waveform output and both flags are all zero.
- R2: In free-running mode, each cycle with `tick` high and no counter write adds one to the counter, and 0xFF wraps to 0x00. Without `tick` the counter holds.
- R3: `ovf_flag` is set on the tick that takes the counter from 0xFF to 0x00. It stays set until `ovf_clr`. If a set and `ovf_clr` fall in the same cycle, the set wins.
- R4: In mode 2 (clear on match), a tick with the counter equal to the compare value loads zero instead of incrementing, so the period is compare+1 ticks.
- R5: Every real compare match sets `cmp_flag`, in any mode. A match is a tick, with no counter write pending, at which the counter equals the compare value. The flag holds until `cmpf_clr`, and a set in the same cycle wins.
- R6: On a real match, the waveform output follows the action field. Action 0 leaves the output unchanged, 1 toggles it, 2 drives it to 0 and 3 drives it to 1.
- R7: Writing the action field never changes the output by itself. The new value governs the next match after the write. A match in the same cycle as the write still uses the previous action.
- R8: `force_cmp` applies the current action to the output at that clock edge, with no tick needed. It sets no flag and does not clear the counter. A force and a real match in the same cycle apply the action only once.
- R9: A counter write takes priority over a tick in the same cycle. The first tick after a write produces no match, even if the written value equals the compare value, but the counter still advances.
- R10: Mode values other than 2 (for example 5 or 7) behave exactly as free-running mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for this cycle |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | WIDTH | Counter write value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | WIDTH | Compare write value |
| mode_we | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode value (2 = clear on match, others free-running) |
| act_we | input | 1 | Action field write strobe |
| act_wdata | input | 2 | Match action (0 none, 1 toggle, 2 clear, 3 set) |
| force_cmp | input | 1 | Apply the match action now |
| ovf_clr | input | 1 | Clear the wrap flag |
| cmpf_clr | input | 1 | Clear the match flag |
| count | output | WIDTH | Current counter value |
| wave_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmp_flag | output | 1 | Sticky match flag |

## Verification
Every result is registered: the counter, both flags and the waveform output show the effect of the inputs at the first rising edge after those inputs are applied, with no further latency. The bench changes inputs only on falling edges and pulses each strobe for exactly one cycle. It reads the outputs at the next falling edge, one full edge after the stimulus. Same-cycle cases (counter write with tick, action write with match, force with match, set with clear) apply all of their inputs in a single cycle, so the result of that one edge is what gets checked.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic [WIDTH-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [WIDTH-1:0] cmp_wdata,
  input  logic             mode_we,
  input  logic [2:0]       mode_wdata,
  input  logic             act_we,
  input  logic [1:0]       act_wdata,
  input  logic             force_cmp,
  input  logic             ovf_clr,
  input  logic             cmpf_clr,
  output logic [WIDTH-1:0] count,
  output logic             wave_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  localparam logic [WIDTH-1:0] MAXV     = '1;
  localparam logic [2:0]       MODE_CTC = 3'd2;

  logic [WIDTH-1:0] cmp_q;
  logic [2:0]       mode_q;
  logic [1:0]       act_q;
  logic             skip_q;
  logic             wave_nx;

  wire ctc  = (mode_q == MODE_CTC);
  wire adv  = tick & ~cnt_we;
  wire hit  = adv & ~skip_q & (count == cmp_q);
  wire wrap = adv & (count == MAXV);
  wire fire = hit | force_cmp;

  always_comb begin
    case (act_q)
      2'd1:    wave_nx = ~wave_out;
      2'd2:    wave_nx = 1'b0;
      2'd3:    wave_nx = 1'b1;
      default: wave_nx = wave_out;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      cmp_q    <= '0;
      mode_q   <= '0;
      act_q    <= '0;
      skip_q   <= 1'b0;
      wave_out <= 1'b0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (cnt_we)          count <= cnt_wdata;
      else if (tick)       count <= (ctc && hit) ? '0 : count + 1'b1;
      if (cnt_we)          skip_q <= 1'b1;
      else if (tick)       skip_q <= 1'b0;
      if (cmp_we)          cmp_q  <= cmp_wdata;
      if (mode_we)         mode_q <= mode_wdata;
      if (act_we)          act_q  <= act_wdata;
      if (fire)            wave_out <= wave_nx;
      if (wrap)            ovf_flag <= 1'b1;
      else if (ovf_clr)    ovf_flag <= 1'b0;
      if (hit)             cmp_flag <= 1'b1;
      else if (cmpf_clr)   cmp_flag <= 1'b0;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> count == '0 || !rst_n); // R1
  AST_FREE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_we && !ctc |=> count == $past(count) + 1'b1); // R2, R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_we |=> $stable(count)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag); // R3
  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctc && hit |=> count == '0); // R4
  AST_CMPF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag && !cmpf_clr |=> cmp_flag); // R5
  AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !force_cmp |=> $stable(wave_out)); // R7
  AST_FORCE_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    force_cmp && !tick && !cmp_flag |=> !cmp_flag); // R8
  AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(cnt_wdata)); // R9
  AST_SKIP_NOMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q && !cnt_we && !cmp_flag |=> !cmp_flag); // R9
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 0, cnt_we = 0, cmp_we = 0, mode_we = 0, act_we = 0;
  logic       force_cmp = 0, ovf_clr = 0, cmpf_clr = 0;
  logic [7:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [2:0] mode_wdata = 0;
  logic [1:0] act_wdata = 0;
  logic [7:0] count;
  logic       wave_out, ovf_flag, cmp_flag;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer #(.WIDTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .act_we(act_we), .act_wdata(act_wdata), .force_cmp(force_cmp), .ovf_clr(ovf_clr),
    .cmpf_clr(cmpf_clr), .count(count), .wave_out(wave_out), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h, want %0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic ticks(int n); tick = 1; repeat (n) step(); tick = 0; endtask
  task automatic wr_cnt(logic [7:0] v); cnt_we = 1; cnt_wdata = v; step(); cnt_we = 0; endtask
  task automatic wr_cmp(logic [7:0] v); cmp_we = 1; cmp_wdata = v; step(); cmp_we = 0; endtask
  task automatic wr_mode(logic [2:0] v); mode_we = 1; mode_wdata = v; step(); mode_we = 0; endtask
  task automatic wr_act(logic [1:0] v); act_we = 1; act_wdata = v; step(); act_we = 0; endtask
  task automatic frc(); force_cmp = 1; step(); force_cmp = 0; endtask
  task automatic clr_flags(); ovf_clr = 1; cmpf_clr = 1; step(); ovf_clr = 0; cmpf_clr = 0; endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 wave", wave_out, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 cmpf", cmp_flag, 0);
  endtask

  task automatic t_free();
    wr_cmp(8'h80);
    wr_cnt(8'hFD);
    ticks(2);
    chk("R2 count FF", count, 8'hFF);
    chk("R3 ovf before wrap", ovf_flag, 0);
    ticks(1);
    chk("R2 wrap", count, 0);
    chk("R3 ovf set", ovf_flag, 1);
    repeat (3) step();
    chk("R2 hold", count, 0);
    chk("R3 sticky", ovf_flag, 1);
    ovf_clr = 1; step(); ovf_clr = 0;
    chk("R3 cleared", ovf_flag, 0);
    wr_cnt(8'hFF);
    tick = 1; ovf_clr = 1; step(); tick = 0; ovf_clr = 0;
    chk("R3 set wins", ovf_flag, 1);
    clr_flags();
  endtask

  task automatic t_ctc();
    wr_mode(3'd2);
    wr_cmp(8'd3);
    wr_cnt(8'd0);
    clr_flags();
    ticks(3);
    chk("R4 reach cmp", count, 3);
    chk("R5 no flag yet", cmp_flag, 0);
    ticks(1);
    chk("R4 cleared", count, 0);
    chk("R5 flag", cmp_flag, 1);
    ticks(4);
    chk("R4 period", count, 0);
    chk("R4 no ovf", ovf_flag, 0);
    cmpf_clr = 1; step(); cmpf_clr = 0;
    chk("R5 cleared", cmp_flag, 0);
    ticks(3);
    tick = 1; cmpf_clr = 1; step(); tick = 0; cmpf_clr = 0;
    chk("R5 set wins", cmp_flag, 1);
    chk("R4 count", count, 0);
  endtask

  task automatic t_actions();
    wr_cmp(8'd1);
    wr_act(2'd3);
    wr_cnt(8'd0);
    ticks(1);
    chk("R6 no match", wave_out, 0);
    ticks(1);
    chk("R6 set", wave_out, 1);
    wr_act(2'd2); ticks(2);
    chk("R6 clear", wave_out, 0);
    wr_act(2'd1); ticks(2);
    chk("R6 toggle 1", wave_out, 1);
    ticks(2);
    chk("R6 toggle 2", wave_out, 0);
    ticks(2);
    chk("R6 toggle 3", wave_out, 1);
    clr_flags();
    wr_act(2'd0); ticks(2);
    chk("R6 none", wave_out, 1);
    chk("R6 none flag", cmp_flag, 1);
  endtask

  task automatic t_deferred();
    wr_act(2'd2);
    chk("R7 write no effect", wave_out, 1);
    ticks(2);
    chk("R7 next match", wave_out, 0);
    ticks(1);
    tick = 1; act_we = 1; act_wdata = 2'd3; step(); tick = 0; act_we = 0;
    chk("R7 same-cycle old", wave_out, 0);
    ticks(2);
    chk("R7 new later", wave_out, 1);
  endtask

  task automatic t_force();
    wr_cmp(8'd5);
    wr_cnt(8'd2);
    clr_flags();
    wr_act(2'd2);
    frc();
    chk("R8 force clear", wave_out, 0);
    chk("R8 count held", count, 2);
    chk("R8 no flag", cmp_flag, 0);
    wr_act(2'd1);
    frc();
    chk("R8 force toggle", wave_out, 1);
    frc();
    chk("R8 force toggle2", wave_out, 0);
    wr_cnt(8'd5);
    frc();
    chk("R8 at cmp wave", wave_out, 1);
    chk("R8 no ctc clear", count, 5);
    chk("R8 no flag at cmp", cmp_flag, 0);
    wr_cnt(8'd4);
    ticks(1);
    tick = 1; force_cmp = 1; step(); tick = 0; force_cmp = 0;
    chk("R8 once", wave_out, 0);
    chk("R8 match cnt", count, 0);
    chk("R8 match flag", cmp_flag, 1);
  endtask

  task automatic t_cnt_write();
    wr_cmp(8'd7);
    clr_flags();
    tick = 1; cnt_we = 1; cnt_wdata = 8'd7; step(); tick = 0; cnt_we = 0;
    chk("R9 write wins", count, 7);
    ticks(1);
    chk("R9 suppressed cnt", count, 8);
    chk("R9 suppressed flag", cmp_flag, 0);
    chk("R9 suppressed wave", wave_out, 0);
    wr_cnt(8'd6);
    ticks(2);
    chk("R9 later match", count, 0);
    chk("R9 later flag", cmp_flag, 1);
    chk("R9 later wave", wave_out, 1);
    wr_mode(3'd0);
    wr_cnt(8'h40);
    ticks(1);
    chk("R9 free write", count, 8'h41);
  endtask

  task automatic t_other_modes();
    wr_mode(3'd5);
    wr_cmp(8'd3);
    wr_cnt(8'd2);
    clr_flags();
    ticks(2);
    chk("R10 no clear", count, 4);
    chk("R10 flag", cmp_flag, 1);
    wr_mode(3'd7);
    wr_cnt(8'hFF);
    clr_flags();
    ticks(1);
    chk("R10 wrap", count, 0);
    chk("R10 ovf", ovf_flag, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_free();
    t_ctc();
    t_actions();
    t_deferred();
    t_force();
    t_cnt_write();
    t_other_modes();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule